// File: doc/BRIEF.md
# Clock Mode Latch and Loss-of-Clock Monitor

This block records the system clock mode from two strap pins while reset is held and decodes the pins into a three-bit mode code. After reset it watches a reference clock. If the reference stops toggling, the block raises a loss-of-clock status bit. That bit stays set until the next reset. Software reads the mode code and the status bit through a one-cycle combinational read port.

The block also tracks a wake-up from a stop state in which the oscillator was powered down with fast wake-up selected. From the stop entry until the oscillator reports ready, the status bit is forced high. During that time a missing reference is recorded even if monitoring is disabled. A pin change during any reset after power-on produces a one-cycle loss-of-lock pulse. In external clock mode the monitor is idle and the status bit always reads zero.

Top module: `clkmode_monitor`

## Requirements
- R1: `mode_pins` is captured on every clock edge at which `rst_n` or `por_n` is low. After both are high, `mode_code` no longer follows the pins.
- R2: The captured pins decode to `mode_code` as follows:
  - 00 gives 000 (external clock).
  - 01 gives 100 (1:1 PLL).
  - 10 gives 110 (PLL with external reference).
  - 11 gives 111 (PLL with crystal reference).
- R3: While `rst_n` is low and `por_n` is high, a change of `mode_pins` from the value captured on the previous edge makes `lol` high for the next cycle. No pulse is produced while `por_n` is low.
- R4: In a PLL mode, `loc_status` goes high when no rising edge of the synchronized `ref_clk` arrives within `LOC_LIMIT` (default 16) clock cycles. A reference with a period of 16 cycles never trips the monitor. A reference with a period of 18 cycles does.
- R5: Once a loss has been recorded, `loc_status` stays high until the next reset, even after the reference recovers.
- R6: A loss is not recorded while `loc_en` is 0, unless a wake-up is pending.
- R7: When `stop_entry` pulses with `fast_wake`=1 and `stop_bits`=11 in a PLL mode, the block behaves as follows:
  - A wake-up becomes pending, and `loc_status` reads 1 from the next cycle regardless of `loc_en`.
  - The wake-up clears on the first edge at which `osc_ready`=1.
  - Any other `stop_bits` value, or `fast_wake`=0, starts no wake-up.
- R8: A loss that occurs while a wake-up is pending is recorded even with `loc_en`=0. The status then stays high after the wake-up ends.
- R9: A loss event that occurs in a cycle where `rd_en` is high is discarded. It is not recorded at all.
- R10: In external clock mode, `loc_status` and `rd_data[2]` are always 0. This holds even across a stop-mode wake-up.
- R11: When `rd_en` is high, `rd_data` holds:
  - `mode_code` in bits 6:4;
  - `loc_status` in bit 2;
  - zero in all other bits.
  
  When `rd_en` is low, `rd_data` is all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| por_n | input | 1 | Power-on reset, active low, asynchronous |
| rst_n | input | 1 | System reset, active low, synchronous |
| mode_pins | input | 2 | Clock-mode strap pins |
| ref_clk | input | 1 | Reference clock under watch (asynchronous) |
| loc_en | input | 1 | Loss-of-clock recording enable |
| stop_entry | input | 1 | One-cycle pulse on entry to stop |
| stop_bits | input | 2 | Stop-mode control bits |
| fast_wake | input | 1 | Fast wake-up enable |
| osc_ready | input | 1 | Oscillator has restarted |
| rd_en | input | 1 | Status register read strobe |
| mode_code | output | 3 | Decoded clock mode |
| loc_status | output | 1 | Sticky loss-of-clock status |
| lol | output | 1 | Loss-of-lock pulse on pin change in reset |
| rd_data | output | 8 | Read data |

## Verification
The monitor's internal state shows up at the ports quickly:
- A wrong mode capture is visible on `mode_code` and `rd_data` in the first cycle after reset.
- A miscounting edge counter either trips `loc_status` within about 20 cycles on an 18-cycle reference, or falsely trips it within 16 cycles on a 16-cycle reference.
- A wrong wake-up flag changes `loc_status` in the cycle after `stop_entry` or after `osc_ready` rises.
- A lost sticky bit reads back as 0 once the reference restarts.
- A read collision that is not discarded leaves `loc_status` set after the read ends.

// File: rtl/clkmode_monitor.sv
module clkmode_monitor #(
  parameter int LOC_LIMIT = 16
) (
  input  logic       clk,
  input  logic       por_n,
  input  logic       rst_n,
  input  logic [1:0] mode_pins,
  input  logic       ref_clk,
  input  logic       loc_en,
  input  logic       stop_entry,
  input  logic [1:0] stop_bits,
  input  logic       fast_wake,
  input  logic       osc_ready,
  input  logic       rd_en,
  output logic [2:0] mode_code,
  output logic       loc_status,
  output logic       lol,
  output logic [7:0] rd_data
);
  localparam int CW = $clog2(LOC_LIMIT + 1);

  logic          in_rst;
  logic [1:0]    pins_q;
  logic          cap_vld;
  logic          lol_q;
  logic [2:0]    ref_sync;
  logic          ref_rise;
  logic [CW-1:0] gap_cnt;
  logic          ext_mode;
  logic          loss_evt;
  logic          wake_set;
  logic          wake_pend;
  logic          sticky;

  assign in_rst = !rst_n || !por_n;

  always_ff @(posedge clk)
    if (in_rst) pins_q <= mode_pins;

  always_ff @(posedge clk or negedge por_n)
    if (!por_n) begin
      cap_vld <= 1'b0;
      lol_q   <= 1'b0;
    end else begin
      lol_q <= !rst_n && cap_vld && (mode_pins != pins_q);
      if (!rst_n) cap_vld <= 1'b1;
    end

  assign mode_code = {|pins_q, pins_q[1], &pins_q};
  assign ext_mode  = (pins_q == 2'b00);
  assign lol       = lol_q;

  always_ff @(posedge clk or negedge por_n)
    if (!por_n) ref_sync <= '0;
    else        ref_sync <= {ref_sync[1:0], ref_clk};

  assign ref_rise = ref_sync[1] && !ref_sync[2];

  always_ff @(posedge clk or negedge por_n)
    if (!por_n)                            gap_cnt <= '0;
    else if (in_rst || ext_mode || ref_rise) gap_cnt <= '0;
    else if (gap_cnt != CW'(LOC_LIMIT))    gap_cnt <= gap_cnt + 1'b1;

  assign loss_evt = !in_rst && !ext_mode && !ref_rise && (gap_cnt == CW'(LOC_LIMIT - 1));
  assign wake_set = stop_entry && fast_wake && (stop_bits == 2'b11) && !ext_mode;

  always_ff @(posedge clk or negedge por_n)
    if (!por_n) begin
      wake_pend <= 1'b0;
      sticky    <= 1'b0;
    end else if (!rst_n) begin
      wake_pend <= 1'b0;
      sticky    <= 1'b0;
    end else begin
      if (wake_set)       wake_pend <= 1'b1;
      else if (osc_ready) wake_pend <= 1'b0;
      if (loss_evt && !rd_en && (loc_en || wake_pend)) sticky <= 1'b1;
    end

  assign loc_status = !ext_mode && (sticky || wake_pend);
  assign rd_data    = rd_en ? {1'b0, mode_code, 1'b0, loc_status, 2'b00} : 8'h00;
endmodule

// File: rtl/clkmode_monitor_chk.sv
module clkmode_monitor_chk (
  input logic       clk,
  input logic       por_n,
  input logic       rst_n,
  input logic [2:0] mode_code,
  input logic       loc_status,
  input logic       lol,
  input logic       rd_en,
  input logic       stop_entry,
  input logic       wake
);
  assert_mode_hold_R1: assert property (@(posedge clk) disable iff (!rst_n || !por_n)
    1'b1 |=> $stable(mode_code));

  assert_lol_only_in_reset_R3: assert property (@(posedge clk) disable iff (!por_n)
    lol |-> $past(!rst_n));

  assert_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n || !por_n)
    (loc_status && !wake) |=> loc_status);

  assert_wake_force_R7: assert property (@(posedge clk) disable iff (!rst_n || !por_n)
    wake |-> loc_status);

  assert_read_drop_R9: assert property (@(posedge clk) disable iff (!rst_n || !por_n)
    (rd_en && !loc_status && !stop_entry) |=> !loc_status);

  assert_ext_zero_R10: assert property (@(posedge clk) disable iff (!rst_n || !por_n)
    (mode_code == 3'b000) |-> !loc_status);
endmodule

bind clkmode_monitor clkmode_monitor_chk u_chk (
  .clk        (clk),
  .por_n      (por_n),
  .rst_n      (rst_n),
  .mode_code  (mode_code),
  .loc_status (loc_status),
  .lol        (lol),
  .rd_en      (rd_en),
  .stop_entry (stop_entry),
  .wake       (wake_pend)
);

// File: tb/clkmode_monitor_tb.sv
module clkmode_monitor_tb;
  logic       clk = 1'b0;
  logic       por_n, rst_n, ref_clk, loc_en, stop_entry, fast_wake, osc_ready, rd_en;
  logic [1:0] mode_pins, stop_bits;
  logic [2:0] mode_code;
  logic       loc_status, lol;
  logic [7:0] rd_data;
  int         n_chk = 0;
  int         n_fail = 0;
  int         ref_half = 0;
  int         ref_cnt = 0;

  always #4ns clk = ~clk;

  clkmode_monitor u_dut (
    .clk(clk), .por_n(por_n), .rst_n(rst_n), .mode_pins(mode_pins), .ref_clk(ref_clk),
    .loc_en(loc_en), .stop_entry(stop_entry), .stop_bits(stop_bits), .fast_wake(fast_wake),
    .osc_ready(osc_ready), .rd_en(rd_en), .mode_code(mode_code), .loc_status(loc_status),
    .lol(lol), .rd_data(rd_data)
  );

  always @(negedge clk)
    if (ref_half == 0) ref_cnt <= 0;
    else if (ref_cnt >= ref_half - 1) begin
      ref_clk <= ~ref_clk;
      ref_cnt <= 0;
    end else ref_cnt <= ref_cnt + 1;

  function automatic logic [2:0] exp_code(input logic [1:0] p);
    case (p)
      2'b00:   return 3'b000;
      2'b01:   return 3'b100;
      2'b10:   return 3'b110;
      default: return 3'b111;
    endcase
  endfunction

  function automatic logic [7:0] exp_rd(input logic [2:0] c, input logic s);
    return {1'b0, c, 1'b0, s, 2'b00};
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic do_rst(input logic [1:0] p);
    @(negedge clk);
    rst_n = 1'b0;
    mode_pins = p;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic stop_pulse(input logic [1:0] bits, input logic fw);
    stop_bits = bits;
    fast_wake = fw;
    stop_entry = 1'b1;
    @(negedge clk);
    stop_entry = 1'b0;
  endtask

  initial begin
    #(8ns * 150000);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    logic [1:0] a, b, junk;
    int seed;
    seed = $urandom(32'h1DC0);
    por_n = 1'b0; rst_n = 1'b0; mode_pins = 2'b10; ref_clk = 1'b0;
    loc_en = 1'b0; stop_entry = 1'b0; stop_bits = 2'b00; fast_wake = 1'b0;
    osc_ready = 1'b1; rd_en = 1'b0;
    repeat (3) @(negedge clk);
    mode_pins = 2'b01;
    @(negedge clk);
    chk(lol == 1'b0, "R3 no pulse during power-on", lol, 0);
    por_n = 1'b1;
    @(negedge clk);
    mode_pins = 2'b11;
    @(negedge clk);
    chk(lol == 1'b1, "R3 pin change in reset", lol, 1);
    @(negedge clk);
    chk(lol == 1'b0, "R3 pulse is one cycle", lol, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(loc_status == 1'b0, "reset state loc_status", loc_status, 0);
    chk(rd_data == 8'h00, "R11 idle rd_data", rd_data, 0);
    chk(mode_code == 3'b111, "R2 reset mode", mode_code, 7);

    for (int i = 0; i < 24; i++) begin
      a = 2'($urandom);
      b = 2'($urandom);
      @(negedge clk);
      rst_n = 1'b0;
      mode_pins = a;
      repeat (2) @(negedge clk);
      mode_pins = b;
      @(negedge clk);
      chk(lol == (a != b), "R3 random pin change", lol, int'(a != b));
      rst_n = 1'b1;
      junk = 2'($urandom);
      mode_pins = junk;
      repeat (3) @(negedge clk);
      chk(mode_code == exp_code(b), "R1 R2 captured mode", mode_code, exp_code(b));
      rd_en = 1'b1;
      #1ns;
      chk(rd_data == exp_rd(exp_code(b), 1'b0), "R11 read layout", rd_data, exp_rd(exp_code(b), 1'b0));
      @(negedge clk);
      rd_en = 1'b0;
    end

    loc_en = 1'b1;
    ref_half = 8;
    do_rst(2'b11);
    repeat (120) @(negedge clk);
    chk(loc_status == 1'b0, "R4 period 16 does not trip", loc_status, 0);
    ref_half = 9;
    repeat (60) @(negedge clk);
    chk(loc_status == 1'b1, "R4 period 18 trips", loc_status, 1);
    ref_half = 4;
    repeat (60) @(negedge clk);
    chk(loc_status == 1'b1, "R5 sticky after recovery", loc_status, 1);
    rd_en = 1'b1;
    #1ns;
    chk(rd_data == exp_rd(3'b111, 1'b1), "R11 read with status", rd_data, exp_rd(3'b111, 1'b1));
    @(negedge clk);
    rd_en = 1'b0;
    do_rst(2'b11);
    chk(loc_status == 1'b0, "R5 reset clears", loc_status, 0);

    loc_en = 1'b0;
    ref_half = 0;
    repeat (50) @(negedge clk);
    chk(loc_status == 1'b0, "R6 disabled monitor", loc_status, 0);

    ref_half = 8;
    do_rst(2'b01);
    loc_en = 1'b1;
    repeat (20) @(negedge clk);
    rd_en = 1'b1;
    ref_half = 0;
    repeat (40) @(negedge clk);
    chk(rd_data[2] == 1'b0, "R9 read in progress", rd_data[2], 0);
    rd_en = 1'b0;
    @(negedge clk);
    chk(loc_status == 1'b0, "R9 colliding event dropped", loc_status, 0);

    ref_half = 8;
    do_rst(2'b10);
    loc_en = 1'b0;
    osc_ready = 1'b0;
    repeat (20) @(negedge clk);
    stop_pulse(2'b11, 1'b1);
    chk(loc_status == 1'b1, "R7 forced on wake", loc_status, 1);
    repeat (10) @(negedge clk);
    chk(loc_status == 1'b1, "R7 held while osc down", loc_status, 1);
    osc_ready = 1'b1;
    @(negedge clk);
    chk(loc_status == 1'b0, "R7 cleared on osc ready", loc_status, 0);
    osc_ready = 1'b0;
    stop_pulse(2'b10, 1'b1);
    chk(loc_status == 1'b0, "R7 other stop bits", loc_status, 0);
    stop_pulse(2'b11, 1'b0);
    chk(loc_status == 1'b0, "R7 no fast wake", loc_status, 0);

    stop_pulse(2'b11, 1'b1);
    ref_half = 0;
    repeat (40) @(negedge clk);
    osc_ready = 1'b1;
    repeat (2) @(negedge clk);
    chk(loc_status == 1'b1, "R8 loss during wake recorded", loc_status, 1);
    ref_half = 8;
    repeat (40) @(negedge clk);
    chk(loc_status == 1'b1, "R5 R8 still sticky", loc_status, 1);

    ref_half = 0;
    loc_en = 1'b1;
    do_rst(2'b00);
    osc_ready = 1'b0;
    stop_pulse(2'b11, 1'b1);
    repeat (40) @(negedge clk);
    chk(loc_status == 1'b0, "R10 external mode status", loc_status, 0);
    rd_en = 1'b1;
    #1ns;
    chk(rd_data == 8'h00, "R10 external mode read", rd_data, 0);
    @(negedge clk);
    rd_en = 1'b0;

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule